// File: doc/BRIEF.md
# Burst Column Address Order Generator

This block turns one column access request into the series of column addresses that a memory burst visits. A start strobe carries the first column address, a burst-length code and a burst-type bit. From the next clock the block puts out one column address per cycle, with a valid flag, until four or eight beats have gone by. A last-beat flag marks the final address.

Only the low column bits inside the burst boundary follow the burst order. These are two bits for a four-beat burst and three bits for an eight-beat burst. Every bit above them keeps its starting value for the whole burst.

Interleaved order XORs the beat number into the low bits. Sequential order counts modulo four inside the starting nibble. At length eight it then moves to the other nibble, so it does not count linearly across all eight beats.

The length code and the type bit are taken at the strobe and held until the burst ends. A start that arrives while a burst is running is ignored. A length code other than the two legal values raises an error pulse and starts nothing.

Top module: `burst_col_seq`

## Requirements
- R1: The burst-length code `bl_sel` selects 4 beats with 3'b010 and 8 beats with 3'b011. A start strobe seen while idle with any other code starts no burst, and `bl_err` is high for exactly the one cycle after that strobe.
- R2: `btype` at 0 selects sequential order and at 1 selects interleaved order.
- R3: In interleaved order, beat i (counting from 0) puts out low bits equal to the starting low bits XOR i. The low field is bits [1:0] at length 4 and bits [2:0] at length 8.
- R4: In sequential order at length 4, beat i puts out bits [1:0] equal to (start[1:0] + i) mod 4. For example, start 2 gives 2,3,0,1.
- R5: In sequential order at length 8, bits [1:0] are (start[1:0] + i) mod 4, and bit 2 is the starting bit 2, inverted for beats 4 to 7. For example, start 5 gives 5,6,7,4,1,2,3,0.
- R6: Every column bit above the low field keeps its starting value on every beat. At length 4 this includes bit 2.
- R7: A start strobe accepted at a clock edge makes `col_valid` high from that edge, with beat 0 equal to the start address. One beat follows per clock for exactly 4 or 8 cycles, and `col_last` is high only on the final beat. The cycle after that is idle.
- R8: `busy` is high for the whole burst. A start strobe seen while busy, including on the last beat, has no effect on the running burst and starts no new one.
- R9: Changes to `bl_sel`, `btype` or `start_col` during a burst do not change its length or its addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe for a new burst |
| start_col | input | COL_W | Starting column address |
| bl_sel | input | 3 | Burst-length code |
| btype | input | 1 | Burst type: 0 sequential, 1 interleaved |
| col_out | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | `col_out` holds a beat |
| col_last | output | 1 | Current beat is the final one |
| busy | output | 1 | A burst is in progress |
| bl_err | output | 1 | One-cycle pulse after a strobe with an illegal length code |

## Verification
Starting addresses are chosen so that the four orders can be told apart.

- Sequential start 5 at length 8 separates nibble wrapping from a linear count and from XOR order.
- Interleaved starts 1, 3 and 6 separate XOR from addition.
- A length-4 start with bit 2 and the upper bits set shows that only two bits move.

Bursts run with the inputs scrambled and the strobe held high throughout. They show that the settings are captured at the strobe and that restarts are ignored, including on the last beat. Illegal codes are applied and checked for the error pulse and the absence of any beat.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned BEAT_W = 3;
  localparam logic [2:0] BLC_4 = 3'b010;
  localparam logic [2:0] BLC_8 = 3'b011;

  // Low three column bits for a given beat; upper bits are handled by caller.
  function automatic logic [BEAT_W-1:0] low_order(
    input logic [BEAT_W-1:0] s,
    input logic [BEAT_W-1:0] idx,
    input logic              is8,
    input logic              inter
  );
    logic [1:0] nib;
    logic       hi;
    if (inter) begin
      nib = s[1:0] ^ idx[1:0];
      hi  = is8 ? (s[2] ^ idx[2]) : s[2];
    end else begin
      nib = s[1:0] + idx[1:0];
      hi  = is8 ? (s[2] ^ idx[2]) : s[2];
    end
    return {hi, nib};
  endfunction

  function automatic logic [BEAT_W-1:0] final_beat(input logic is8);
    return is8 ? 3'd7 : 3'd3;
  endfunction
endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
  import burst_pkg::*;
(
  input  logic [2:0] bl_sel,
  output logic       legal,
  output logic       is8
);
  always_comb begin
    legal = (bl_sel == BLC_4) || (bl_sel == BLC_8);
    is8   = (bl_sel == BLC_8);
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              is8,
  output logic              active,
  output logic [BEAT_W-1:0] idx,
  output logic              last
);
  always_comb last = active && (idx == final_beat(is8));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (active) begin
      if (last) begin
        active <= 1'b0;
        idx    <= '0;
      end else begin
        idx <= idx + 3'd1;
      end
    end else if (accept) begin
      active <= 1'b1;
      idx    <= '0;
    end
  end
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import burst_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0]  base,
  input  logic [BEAT_W-1:0] idx,
  input  logic              is8,
  input  logic              inter,
  output logic [COL_W-1:0]  col
);
  localparam int unsigned HI_W = COL_W - BEAT_W;
  logic [BEAT_W-1:0] low;
  always_comb begin
    low = low_order(base[BEAT_W-1:0], idx, is8, inter);
    col = {base[COL_W-1 -: HI_W], low};
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_sel,
  input  logic             btype,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             col_last,
  output logic             busy,
  output logic             bl_err
);
  logic              code_legal;
  logic              code_is8;
  logic              accept;
  logic              reject;
  logic              cfg_is8;
  logic              cfg_inter;
  logic [COL_W-1:0]  base_col;
  logic              active;
  logic [BEAT_W-1:0] beat_idx;
  logic              last_beat;

  burst_cfg_decode u_dec (
    .bl_sel (bl_sel),
    .legal  (code_legal),
    .is8    (code_is8)
  );

  always_comb begin
    accept = start && !active && code_legal;
    reject = start && !active && !code_legal;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_is8   <= 1'b0;
      cfg_inter <= 1'b0;
      base_col  <= '0;
      bl_err    <= 1'b0;
    end else begin
      bl_err <= reject;
      if (accept) begin
        cfg_is8   <= code_is8;
        cfg_inter <= btype;
        base_col  <= start_col;
      end
    end
  end

  burst_beat_ctr u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .is8    (cfg_is8),
    .active (active),
    .idx    (beat_idx),
    .last   (last_beat)
  );

  burst_addr_map #(.COL_W(COL_W)) u_map (
    .base  (base_col),
    .idx   (beat_idx),
    .is8   (cfg_is8),
    .inter (cfg_inter),
    .col   (col_out)
  );

  always_comb begin
    col_valid = active;
    col_last  = last_beat;
    busy      = active;
  end
endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk #(
  parameter int unsigned COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] col_out,
  input logic             col_valid,
  input logic             col_last,
  input logic             busy,
  input logic             bl_err,
  input logic [2:0]       beat_idx
);
  // R7
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);
  // R7
  end_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(col_valid) |-> $past(col_last));
  // R7
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_valid) |-> (col_out == $past(start_col)) && (beat_idx == 3'd0));
  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_last) |=> col_valid && (beat_idx == $past(beat_idx) + 3'd1));
  // R6
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_last) |=> (col_out[COL_W-1:3] == $past(col_out[COL_W-1:3])));
  // R1
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bl_err |-> !col_valid && !busy);
  // R8
  busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy == col_valid);
endmodule

bind burst_col_seq burst_col_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_col (start_col),
  .col_out   (col_out),
  .col_valid (col_valid),
  .col_last  (col_last),
  .busy      (busy),
  .bl_err    (bl_err),
  .beat_idx  (beat_idx)
);

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;
  localparam int COL_W = 10;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0] bl_sel = 3'b010;
  logic btype = 1'b0;
  logic [COL_W-1:0] col_out;
  logic col_valid, col_last, busy, bl_err;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .bl_sel(bl_sel), .btype(btype), .col_out(col_out), .col_valid(col_valid),
    .col_last(col_last), .busy(busy), .bl_err(bl_err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected address from the requirement text, written as separate cases.
  function automatic int expect_col(input int s, input int i, input bit len8, input bit inter);
    int r;
    if (inter) begin
      r = s ^ i;
    end else if (!len8) begin
      r = (s & ~3) | ((s + i) % 4);
    end else begin
      r = (s & ~7) | (((s % 4) + i) % 4) | ((s & 4) ^ ((i >= 4) ? 4 : 0));
    end
    return r;
  endfunction

  // One burst; when disturb is set, inputs are scrambled and start held high during it.
  task automatic run_burst(input string req, input int s, input bit len8,
                           input bit inter, input bit disturb);
    int n;
    n = len8 ? 8 : 4;
    @(negedge clk);
    start = 1'b1; start_col = COL_W'(s); bl_sel = len8 ? 3'b011 : 3'b010; btype = inter;
    @(negedge clk);
    if (disturb) begin
      start_col = ~COL_W'(s); bl_sel = len8 ? 3'b010 : 3'b011; btype = ~inter;
    end else begin
      start = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      check({req, " valid"}, int'(col_valid), 1);
      check({req, " R8 busy"}, int'(busy), 1);
      check({req, " addr"}, int'(col_out), expect_col(s, i, len8, inter));
      check({req, " R7 last"}, int'(col_last), (i == n - 1) ? 1 : 0);
      @(negedge clk);
    end
    start = 1'b0;
    check({req, " R7 idle after"}, int'(col_valid), 0);
    check({req, " R8 busy low"}, int'(busy), 0);
  endtask

  task automatic t_reset();
    check("R7 reset valid", int'(col_valid), 0);
    check("R8 reset busy", int'(busy), 0);
    check("R1 reset err", int'(bl_err), 0);
  endtask

  task automatic t_illegal(input logic [2:0] code);
    @(negedge clk);
    start = 1'b1; start_col = 10'h155; bl_sel = code;
    @(negedge clk);
    start = 1'b0; bl_sel = 3'b010;
    check("R1 err pulse", int'(bl_err), 1);
    check("R1 no burst", int'(col_valid), 0);
    @(negedge clk);
    check("R1 err one cycle", int'(bl_err), 0);
    check("R1 still idle", int'(col_valid), 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    run_burst("R4 R2 seq4 s2", 10'h012, 1'b0, 1'b0, 1'b0);
    run_burst("R5 seq8 s5", 10'h2A5, 1'b1, 1'b0, 1'b0);
    run_burst("R5 seq8 s3", 10'h003, 1'b1, 1'b0, 1'b0);
    run_burst("R3 R2 int4 s1", 10'h101, 1'b0, 1'b1, 1'b0);
    run_burst("R3 int8 s6", 10'h0F6, 1'b1, 1'b1, 1'b0);
    run_burst("R3 int8 s3", 10'h3C3, 1'b1, 1'b1, 1'b0);
    run_burst("R6 seq4 bit2 held", 10'h3FE, 1'b0, 1'b0, 1'b0);
    run_burst("R6 int4 bit2 held", 10'h2F7, 1'b0, 1'b1, 1'b0);
    run_burst("R9 R8 seq8 disturbed", 10'h1A5, 1'b1, 1'b0, 1'b1);
    run_burst("R9 R8 int4 disturbed", 10'h0C2, 1'b0, 1'b1, 1'b1);
    t_illegal(3'b100);
    t_illegal(3'b000);
    run_burst("R7 after err", 10'h004, 1'b0, 1'b0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule